// File: doc/BRIEF.md
# Bit-band alias bus bridge

This bridge sits between a 32-bit processor-side bus and a word-wide memory or peripheral bus. It watches every upstream access for two 32 MB alias windows, one based at 0x22000000 and one at 0x42000000. Inside such a window every aligned alias word stands for one bit of a real data word. The real word lies in a 1 MB data window based at 0x20000000 or 0x40000000 respectively. The real word address is `data_base + (alias_offset / 128) * 4` and the bit number is `(alias_offset / 4) mod 32`.

A store to an alias word sets or clears that single bit. The bridge does this as a locked read of the real word followed by a write of the same word, with the one bit replaced. A load from an alias word reads the real word once and returns the selected bit in bit 0. All other addresses are forwarded as one downstream transfer with address, data and direction unchanged. The upstream side is stalled until the last downstream transfer of the operation completes.

Handshake on both sides: a requester raises `req` with stable fields and holds them until `ready` is high for one cycle. Read data is valid in that cycle.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `up_ready`, `dn_req` and `dn_lock` are low.
- R2: An access whose address lies outside 0x22000000–0x23FFFFFF and 0x42000000–0x43FFFFFF causes exactly one downstream transfer with the same address, direction and write data. A read returns `dn_rdata` on `up_rdata`.
- R3: An alias address A in 0x22000000–0x23FFFFFF targets real word 0x20000000 + ((A−0x22000000)/128)·4, bit ((A−0x22000000)/4) mod 32. For example, 0x2200000C is bit 3 of 0x20000000, and 0x23FFFFFC is bit 31 of 0x200FFFFC.
- R4: An alias address A in 0x42000000–0x43FFFFFF targets real word 0x40000000 + ((A−0x42000000)/128)·4, bit ((A−0x42000000)/4) mod 32.
- R5: An alias read causes exactly one downstream read of the real word. It returns the target bit in `up_rdata[0]`, with bits 31:1 zero.
- R6: An alias write causes a downstream read of the real word, then a downstream write to the same address. The written word equals the read word with the target bit replaced by `up_wdata[0]`. Bits 31:1 of the alias write data have no effect.
- R7: `dn_lock` is high during both transfers of an alias write and falls only after its write transfer completes. A competing master gated by `dn_lock` therefore cannot change the word between the read and the write.
- R8: `up_ready` stays low until the final downstream transfer of the operation has completed, and is then high for exactly one cycle.
- R9: While `dn_req` is high and `dn_ready` is low, `dn_req`, `dn_addr`, `dn_we` and `dn_wdata` hold their values.
- R10: Bits 1:0 of an alias address are ignored. Downstream addresses produced for alias accesses have bits 1:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream access request, held until up_ready |
| up_we | input | 1 | Upstream direction, 1 = write |
| up_addr | input | 32 | Upstream byte address |
| up_wdata | input | 32 | Upstream write data (bit 0 only for alias writes) |
| up_ready | output | 1 | One-cycle completion pulse to upstream |
| up_rdata | output | 32 | Upstream read data, valid with up_ready |
| dn_req | output | 1 | Downstream transfer request |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_ready | input | 1 | Downstream transfer completion |
| dn_rdata | input | 32 | Downstream read data, valid with dn_ready |
| dn_lock | output | 1 | High while an alias read-modify-write owns the bus |

## Verification
The sensitive coincidence is a competing master's write to the target word landing in the same cycle as the completion of the read half of an alias write. That is exactly the gap an unlocked read-modify-write would lose. The bench arms a competitor on the word and fires it in the cycle the slave model serves that read, gated only by `dn_lock`. The competitor must therefore be deferred until after the write half. A later plain read must return the competitor's value rather than the bridge's merged word.

// File: rtl/bb_pkg.sv
package bb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_AREAD,
    ST_AWRITE,
    ST_DONE
  } bb_state_e;

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DREG_W  = 20,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] DATA_BASE  = {32'h4000_0000, 32'h2000_0000},
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int AL_W   = DREG_W + BIT_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] real_addr,
  output logic [BIT_W-1:0]  bit_idx
);

  logic [NUM_WIN-1:0]             win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_addr;
  logic [AL_W-1:0]                off;

  // Window bases are aligned to the window size, so the offset is a slice.
  assign off = addr[AL_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [DREG_W-1:0] word_off;
    assign win_hit[w]  = (addr[ADDR_W-1:AL_W] == ALIAS_BASE[w][ADDR_W-1:AL_W]);
    assign word_off    = DREG_W'((off >> (BIT_W + BYTE_W)) << BYTE_W);
    assign win_addr[w] = DATA_BASE[w] | {{(ADDR_W-DREG_W){1'b0}}, word_off};
  end

  always_comb begin
    hit       = 1'b0;
    real_addr = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_hit[w] && !hit) begin
        hit       = 1'b1;
        real_addr = win_addr[w];
      end
    end
  end

  assign bit_idx = BIT_W'(off >> BYTE_W);

  always_comb begin
    assert_align_R10 : assert (!hit || real_addr[BYTE_W-1:0] == '0)
      else $error("alias real address not word aligned");
  end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              new_val,
  output logic [DATA_W-1:0] merged,
  output logic              picked
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (bit_idx == BIT_W'(i)) ? new_val : word[i];
  end

  assign picked = word[bit_idx];

endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  input  logic              dec_hit,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [BIT_W-1:0]  dec_bit,
  output logic [BIT_W-1:0]  op_bit,
  output logic              op_val,
  input  logic [DATA_W-1:0] mrg_word,
  input  logic              mrg_bit,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              dn_lock
);

  bb_state_e st;
  logic      op_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      up_ready <= 1'b0;
      up_rdata <= '0;
      dn_req   <= 1'b0;
      dn_we    <= 1'b0;
      dn_addr  <= '0;
      dn_wdata <= '0;
      dn_lock  <= 1'b0;
      op_we    <= 1'b0;
      op_bit   <= '0;
      op_val   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (up_req) begin
            op_we  <= up_we;
            op_bit <= dec_bit;
            op_val <= up_wdata[0];
            dn_req <= 1'b1;
            if (dec_hit) begin
              dn_addr <= dec_addr;
              dn_we   <= 1'b0;
              dn_lock <= up_we;
              st      <= ST_AREAD;
            end else begin
              dn_addr  <= up_addr;
              dn_we    <= up_we;
              dn_wdata <= up_wdata;
              st       <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          if (dn_ready) begin
            dn_req   <= 1'b0;
            dn_we    <= 1'b0;
            up_rdata <= op_we ? '0 : dn_rdata;
            up_ready <= 1'b1;
            st       <= ST_DONE;
          end
        end
        ST_AREAD: begin
          if (dn_ready) begin
            if (op_we) begin
              dn_we    <= 1'b1;
              dn_wdata <= mrg_word;
              st       <= ST_AWRITE;
            end else begin
              dn_req   <= 1'b0;
              up_rdata <= {{(DATA_W-1){1'b0}}, mrg_bit};
              up_ready <= 1'b1;
              st       <= ST_DONE;
            end
          end
        end
        ST_AWRITE: begin
          if (dn_ready) begin
            dn_req   <= 1'b0;
            dn_we    <= 1'b0;
            dn_lock  <= 1'b0;
            up_rdata <= '0;
            up_ready <= 1'b1;
            st       <= ST_DONE;
          end
        end
        ST_DONE: begin
          up_ready <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_ready_pulse_R8 : assert property (@(posedge clk) disable iff (rst)
    up_ready |=> !up_ready);

  assert_hold_R9 : assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  assert_rmw_onebit_R6 : assert property (@(posedge clk) disable iff (rst)
    (st == ST_AREAD && dn_ready && op_we) |=>
      (dn_req && dn_we && $stable(dn_addr) && $countones(dn_wdata ^ $past(dn_rdata)) <= 1));

  assert_lock_release_R7 : assert property (@(posedge clk) disable iff (rst)
    $fell(dn_lock) |-> $past(dn_req && dn_we && dn_ready));

  assert_lock_start_R7 : assert property (@(posedge clk) disable iff (rst)
    $rose(dn_lock) |-> (dn_req && !dn_we));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DREG_W  = 20,
  parameter int NUM_WIN = 2,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] DATA_BASE  = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              dn_lock
);

  localparam int BIT_W = $clog2(DATA_W);

  logic              dec_hit;
  logic [ADDR_W-1:0] dec_addr;
  logic [BIT_W-1:0]  dec_bit;
  logic [BIT_W-1:0]  op_bit;
  logic              op_val;
  logic [DATA_W-1:0] mrg_word;
  logic              mrg_bit;

  bb_alias_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DREG_W(DREG_W), .NUM_WIN(NUM_WIN),
    .ALIAS_BASE(ALIAS_BASE), .DATA_BASE(DATA_BASE)
  ) u_dec (
    .addr(up_addr), .hit(dec_hit), .real_addr(dec_addr), .bit_idx(dec_bit)
  );

  bb_bit_merge #(.DATA_W(DATA_W)) u_mrg (
    .word(dn_rdata), .bit_idx(op_bit), .new_val(op_val),
    .merged(mrg_word), .picked(mrg_bit)
  );

  bb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dec_hit(dec_hit), .dec_addr(dec_addr), .dec_bit(dec_bit),
    .op_bit(op_bit), .op_val(op_val),
    .mrg_word(mrg_word), .mrg_bit(mrg_bit),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ready(dn_ready), .dn_rdata(dn_rdata), .dn_lock(dn_lock)
  );

endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        up_req, up_we;
  logic [31:0] up_addr, up_wdata, up_rdata;
  logic        up_ready;
  logic        dn_req, dn_we, dn_lock;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ready;
  logic [31:0] dn_rdata;

  bitband_bridge u_dut (
    .clk(clk), .rst(rst),
    .up_req(up_req), .up_we(up_we), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ready(dn_ready), .dn_rdata(dn_rdata), .dn_lock(dn_lock)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic        we;
    logic        lk;
    logic [31:0] addr;
    logic [31:0] wdata;
  } xf_t;

  xf_t   exp_q[$];
  string tag_q[$];
  xf_t   cur;
  string cur_tag;
  logic [31:0] mem [logic [31:0]];

  int dn_count = 0;
  int wait_cnt = 0;
  int xfer_no  = 0;
  logic [31:0] hold_addr;
  logic        hold_we;
  bit          comp_arm = 0;
  bit          comp_pending = 0;
  logic [31:0] comp_addr = '0;
  logic [31:0] comp_val = '0;

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural alias mapping, written from the requirement formulas
  function automatic bit alias_map(input logic [31:0] a, output logic [31:0] ra, output int b);
    logic [31:0] ab, db, off;
    ra = '0;
    b  = 0;
    if (a >= 32'h2200_0000 && a <= 32'h23FF_FFFF) begin
      ab = 32'h2200_0000; db = 32'h2000_0000;
    end else if (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF) begin
      ab = 32'h4200_0000; db = 32'h4000_0000;
    end else return 0;
    off = a - ab;
    ra  = db + (off / 128) * 4;
    b   = int'((off / 4) % 32);
    return 1;
  endfunction

  // Downstream slave model with varying latency and a competing master
  always @(negedge clk) begin
    dn_ready = 1'b0;
    if (!rst && dn_req) begin
      if (wait_cnt > 0) begin
        chk("R9 address held while waiting", dn_addr, hold_addr);
        chk("R9 direction held while waiting", {31'b0, dn_we}, {31'b0, hold_we});
      end
      if (wait_cnt >= xfer_no % 4) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2 unexpected downstream transfer: actual %h expected none", dn_addr);
        end else begin
          cur = exp_q.pop_front();
          cur_tag = tag_q.pop_front();
          chk({cur_tag, " direction"}, {31'b0, dn_we}, {31'b0, cur.we});
          chk({cur_tag, " address"}, dn_addr, cur.addr);
          if (cur.we) chk({cur_tag, " write data"}, dn_wdata, cur.wdata);
          chk("R7 lock level during transfer", {31'b0, dn_lock}, {31'b0, cur.lk});
          chk("R10 downstream address aligned", {30'b0, dn_addr[1:0]}, 32'h0);
        end
        if (dn_we) mem[dn_addr] = dn_wdata;
        else dn_rdata = memrd(dn_addr);
        if (comp_arm && !dn_we && dn_addr == comp_addr) begin
          comp_pending = 1;
          comp_arm = 0;
        end
        dn_ready = 1'b1;
        dn_count++;
        wait_cnt = 0;
        xfer_no++;
      end else begin
        hold_addr = dn_addr;
        hold_we   = dn_we;
        wait_cnt++;
      end
    end
    if (comp_pending && !dn_lock) begin
      mem[comp_addr] = comp_val;
      comp_pending = 0;
    end
  end

  task automatic access(input string tag, input logic we, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    logic [31:0] ra, old, expr;
    int b, nexp, n0, cyc;
    bit al;
    al = alias_map(a, ra, b);
    expr = '0;
    if (!al) begin
      exp_q.push_back('{we: we, lk: 1'b0, addr: a, wdata: wd});
      tag_q.push_back(tag);
      expr = memrd(a);
      nexp = 1;
    end else if (!we) begin
      exp_q.push_back('{we: 1'b0, lk: 1'b0, addr: ra, wdata: '0});
      tag_q.push_back(tag);
      expr = (memrd(ra) >> b) & 32'h1;
      nexp = 1;
    end else begin
      old = memrd(ra);
      exp_q.push_back('{we: 1'b0, lk: 1'b1, addr: ra, wdata: '0});
      tag_q.push_back(tag);
      old[b] = wd[0];
      exp_q.push_back('{we: 1'b1, lk: 1'b1, addr: ra, wdata: old});
      tag_q.push_back(tag);
      nexp = 2;
    end
    n0 = dn_count;
    up_req = 1'b1; up_we = we; up_addr = a; up_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!up_ready && cyc < 60);
    chk("R8 ready only after final downstream transfer", dn_count - n0, nexp);
    rd = up_rdata;
    if (!we) chk({tag, " read data"}, up_rdata, expr);
    up_req = 1'b0; up_we = 1'b0;
    @(negedge clk);
    chk("R8 ready lasts one cycle", {31'b0, up_ready}, 32'h0);
    chk("R9 no leftover expected transfer", exp_q.size(), 0);
  endtask

  initial begin
    logic [31:0] rd;
    rst = 1'b1; up_req = 0; up_we = 0; up_addr = '0; up_wdata = '0;
    dn_ready = 0; dn_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 up_ready in reset", {31'b0, up_ready}, 32'h0);
    chk("R1 dn_req in reset", {31'b0, dn_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dn_lock after reset", {31'b0, dn_lock}, 32'h0);
    chk("R1 dn_req after reset", {31'b0, dn_req}, 32'h0);

    // R2: plain forwarding, both directions and window edges
    access("R2 pass write", 1, 32'h1000_0000, 32'hDEAD_BEEF, rd);
    access("R2 pass read", 0, 32'h1000_0000, 0, rd);
    chk("R2 readback", rd, 32'hDEAD_BEEF);
    access("R2 below lower window", 0, 32'h21FF_FFFC, 0, rd);
    access("R2 above lower window", 1, 32'h2400_0000, 32'h0000_1111, rd);
    access("R2 above upper window", 0, 32'h4400_0000, 0, rd);

    // R3/R5: lower window reads
    access("R2 seed word", 1, 32'h2000_0000, 32'h0000_0048, rd);
    access("R3 bit3 alias read", 0, 32'h2200_000C, 0, rd);
    chk("R5 bit3 value", rd, 32'h1);
    access("R3 bit6 alias read", 0, 32'h2200_0018, 0, rd);
    chk("R5 bit6 value", rd, 32'h1);
    access("R5 bit4 alias read", 0, 32'h2200_0010, 0, rd);
    chk("R5 clear bit returns zero", rd, 32'h0);

    // R6: set and clear, upper data bits ignored
    access("R2 seed word", 1, 32'h2000_0004, 32'hA5A5_0000, rd);
    access("R6 set bit0", 1, 32'h2200_0080, 32'h0000_0001, rd);
    access("R6 readback", 0, 32'h2000_0004, 0, rd);
    chk("R6 only bit0 set", rd, 32'hA5A5_0001);
    access("R2 seed word", 1, 32'h2000_0008, 32'hFFFF_FFFF, rd);
    access("R6 clear bit0 with upper bits set", 1, 32'h2200_0100, 32'hFFFF_FFFE, rd);
    access("R6 readback", 0, 32'h2000_0008, 0, rd);
    chk("R6 only bit0 cleared", rd, 32'hFFFF_FFFE);

    // R3 boundary, R10 low address bits ignored
    access("R3 top alias word", 1, 32'h23FF_FFFC, 32'h0, rd);
    access("R3 top word readback", 0, 32'h200F_FFFC, 0, rd);
    chk("R3 bit31 of last word cleared", rd[31], 1'b0);
    access("R10 unaligned alias read", 0, 32'h2200_000F, 0, rd);
    chk("R10 same bit as aligned", rd, 32'h1);

    // R4: upper window
    access("R2 seed word", 1, 32'h4000_0100, 32'h0000_0000, rd);
    access("R4 set bit17", 1, 32'h4200_2000 + 17 * 4, 32'h1, rd);
    access("R4 readback", 0, 32'h4000_0100, 0, rd);
    chk("R4 bit17 set", rd, 32'h0002_0000);
    access("R4 alias read", 0, 32'h4200_2000 + 17 * 4, 0, rd);
    chk("R4 alias read bit17", rd, 32'h1);

    // R7: competitor fires when the read half completes
    access("R2 seed word", 1, 32'h2000_0010, 32'h0000_00F0, rd);
    comp_addr = 32'h2000_0010;
    comp_val  = 32'h1234_5670;
    comp_arm  = 1;
    access("R7 locked alias write", 1, 32'h2200_0200, 32'h1, rd);
    repeat (2) @(negedge clk);
    access("R7 readback", 0, 32'h2000_0010, 0, rd);
    chk("R7 competitor write not lost", rd, 32'h1234_5670);

    // Mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a;
      int k;
      k = int'($urandom % 4);
      case (k)
        0: a = 32'h1000_0040 + ($urandom % 8) * 4;
        1: a = 32'h2200_0000 + ($urandom % 4) * 128 + ($urandom % 32) * 4;
        2: a = 32'h4200_0000 + ($urandom % 4) * 128 + ($urandom % 32) * 4;
        default: a = 32'h2000_0000 + ($urandom % 4) * 4;
      endcase
      access("R5/R6 mixed traffic", 1'($urandom % 2), a, $urandom, rd);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule